// File: doc/BRIEF.md
# Branch Target Buffer

This block predicts the next fetch address in the same cycle the fetch address is presented. It works alongside the PC+4 incrementer, before the instruction word has been read. The block holds a small table of previously seen control-transfer instructions. The table is organised as 16 sets of 2 ways. Each entry holds a valid bit, the complete 32-bit address of the branch as its tag, and the last resolved target. Bits [5:2] of the fetch address select a set, and both ways of that set are compared against the whole address at once. A match proves that the word being fetched is a known branch, with no decoding needed. The taken/not-taken decision comes from a separate direction predictor through `fetch_taken`. The stored target is used only when the table hits and the direction input says taken.

Training arrives on an update port when a branch or jump resolves. The update carries the branch address, its actual target and a flag saying whether the instruction is a control transfer. Only control transfers are written. If the address is already present, its target is overwritten in place. Otherwise a way is allocated: an empty way is used first, and a single per-set LRU bit picks the victim when both ways are full.

The lookup path is purely combinational and has no handshake. The update port has a `upd_valid` qualifier and no ready signal: the table accepts one update in every cycle, so it never applies back-pressure.

Top module: `btb_predictor`

## Requirements
- R1: After reset every entry is invalid, so every lookup reports `fetch_hit`=0 and `fetch_next_pc` = `fetch_pc`+4 (modulo 2^32) until training occurs.
- R2: A lookup hits only when a valid entry in the set selected by `fetch_pc[5:2]` stores exactly the full 32-bit `fetch_pc`. An address that shares the set but differs in any other bit misses.
- R3: `fetch_next_pc` equals the stored target when `fetch_hit`=1 and `fetch_taken`=1. In every other case it equals `fetch_pc`+4, including on a hit with `fetch_taken`=0.
- R4: A branch that has never been trained misses. An update with `upd_valid`=1 and `upd_is_branch`=1 for an address not in its set allocates an entry, and later lookups of that address hit with `upd_target`.
- R5: An update with `upd_is_branch`=0, or any cycle with `upd_valid`=0, leaves every entry unchanged.
- R6: An update whose address already hits in its set overwrites that entry's target in the same way and never creates a second copy. At most one way of a set ever matches a given address.
- R7: Each set holds two independent entries. `fetch_way` reports the way that hit (0 or 1) and is meaningful only while `fetch_hit`=1.
- R8: Allocation uses way 0 if it is invalid, else way 1 if it is invalid. When both ways are valid, the way not written most recently is replaced. Every write, whether an allocation or an in-place overwrite, makes the written way the most recent. Lookups do not change the replacement order.
- R9: An update takes effect at the clock edge that ends its cycle. A lookup presented in the same cycle sees the table as it was before the update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset; invalidates all entries |
| fetch_pc | input | 32 | Address being fetched this cycle |
| fetch_taken | input | 1 | Taken decision from the direction predictor |
| fetch_next_pc | output | 32 | Predicted next fetch address |
| fetch_hit | output | 1 | A valid entry matches the full `fetch_pc` |
| fetch_way | output | 1 | Way that hit |
| upd_valid | input | 1 | An update is presented this cycle |
| upd_pc | input | 32 | Address of the resolved instruction |
| upd_target | input | 32 | Resolved target address |
| upd_is_branch | input | 1 | The resolved instruction is a control transfer |

## Verification
The bench builds the block with its defaults: 16 sets, 2 ways and 32-bit addresses. With these values, addresses 0x40 apart share a set, so a few hand-picked addresses are enough to fill a set, force allocation into both ways and drive two rounds of LRU replacement. The full 32-bit tag lets the bench flip only the top address bit to show that a near-alias misses. Looking up 0xFFFFFFFC shows the PC+4 path wrapping to zero. Running a lookup and an update of the same address together exposes the one-edge write latency.

// File: rtl/btb_pkg.sv
package btb_pkg;

  localparam int BTB_PC_W_DEF = 32;
  localparam int BTB_SETS_DEF = 16;
  localparam int BTB_WORD_OFF = 2;

  // Way chosen for a new allocation: empty ways first, lowest first,
  // otherwise the way named by the per-set LRU bit.
  function automatic logic pick_victim(input logic v0, input logic v1,
                                       input logic lru_way);
    if (!v0)      return 1'b0;
    else if (!v1) return 1'b1;
    else          return lru_way;
  endfunction

endpackage

// File: rtl/btb_way.sv
module btb_way #(
  parameter int PC_W  = 32,
  parameter int SETS  = 16,
  parameter int IDX_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] f_idx,
  output logic             f_valid,
  output logic [PC_W-1:0]  f_tag,
  output logic [PC_W-1:0]  f_tgt,
  input  logic [IDX_W-1:0] u_idx,
  output logic             u_valid,
  output logic [PC_W-1:0]  u_tag,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [PC_W-1:0]  wr_tag,
  input  logic [PC_W-1:0]  wr_tgt,
  output logic [SETS-1:0]  valid_vec
);

  logic [SETS-1:0] valid_q;
  logic [PC_W-1:0] tag_q [SETS];
  logic [PC_W-1:0] tgt_q [SETS];

  always_ff @(posedge clk) begin
    if (rst)        valid_q <= '0;
    else if (wr_en) valid_q[wr_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx] <= wr_tag;
      tgt_q[wr_idx] <= wr_tgt;
    end
  end

  assign f_valid   = valid_q[f_idx];
  assign f_tag     = tag_q[f_idx];
  assign f_tgt     = tgt_q[f_idx];
  assign u_valid   = valid_q[u_idx];
  assign u_tag     = tag_q[u_idx];
  assign valid_vec = valid_q;

  // R4
  write_lands_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (valid_q[$past(wr_idx)] && tag_q[$past(wr_idx)] == $past(wr_tag)));

endmodule

// File: rtl/btb_lru.sv
module btb_lru #(
  parameter int SETS  = 16,
  parameter int IDX_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             touch,
  input  logic [IDX_W-1:0] touch_idx,
  input  logic             touch_way,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             victim_way
);

  // Each bit names the way to evict next in its set.
  logic [SETS-1:0] lru_q;

  always_ff @(posedge clk) begin
    if (rst)        lru_q <= '0;
    else if (touch) lru_q[touch_idx] <= ~touch_way;
  end

  assign victim_way = lru_q[rd_idx];

endmodule

// File: rtl/btb_predictor.sv
module btb_predictor
  import btb_pkg::*;
#(
  parameter int PC_W = BTB_PC_W_DEF,
  parameter int SETS = BTB_SETS_DEF
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PC_W-1:0] fetch_pc,
  input  logic            fetch_taken,
  output logic [PC_W-1:0] fetch_next_pc,
  output logic            fetch_hit,
  output logic            fetch_way,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic [PC_W-1:0] upd_target,
  input  logic            upd_is_branch
);

  localparam int WAYS  = 2;
  localparam int IDX_W = $clog2(SETS);

  logic [IDX_W-1:0] f_idx, u_idx;
  assign f_idx = fetch_pc[BTB_WORD_OFF +: IDX_W];
  assign u_idx = upd_pc[BTB_WORD_OFF +: IDX_W];

  logic            f_valid [WAYS];
  logic [PC_W-1:0] f_tag   [WAYS];
  logic [PC_W-1:0] f_tgt   [WAYS];
  logic            u_valid [WAYS];
  logic [PC_W-1:0] u_tag   [WAYS];
  logic [SETS-1:0] vvec    [WAYS];
  logic [WAYS-1:0] way_hit, upd_match, wr_en;

  logic wr_go, wr_way, lru_victim;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    btb_way #(.PC_W(PC_W), .SETS(SETS), .IDX_W(IDX_W)) u_way (
      .clk      (clk),
      .rst      (rst),
      .f_idx    (f_idx),
      .f_valid  (f_valid[w]),
      .f_tag    (f_tag[w]),
      .f_tgt    (f_tgt[w]),
      .u_idx    (u_idx),
      .u_valid  (u_valid[w]),
      .u_tag    (u_tag[w]),
      .wr_en    (wr_en[w]),
      .wr_idx   (u_idx),
      .wr_tag   (upd_pc),
      .wr_tgt   (upd_target),
      .valid_vec(vvec[w])
    );
    assign way_hit[w]   = f_valid[w] && (f_tag[w] == fetch_pc);
    assign upd_match[w] = u_valid[w] && (u_tag[w] == upd_pc);
    assign wr_en[w]     = wr_go && (wr_way == 1'(w));
  end

  btb_lru #(.SETS(SETS), .IDX_W(IDX_W)) u_lru (
    .clk       (clk),
    .rst       (rst),
    .touch     (wr_go),
    .touch_idx (u_idx),
    .touch_way (wr_way),
    .rd_idx    (u_idx),
    .victim_way(lru_victim)
  );

  // Update side: overwrite in place on a match, else allocate.
  assign wr_go = upd_valid && upd_is_branch;
  always_comb begin
    if (|upd_match) wr_way = upd_match[1];
    else            wr_way = pick_victim(u_valid[0], u_valid[1], lru_victim);
  end

  // Fetch side: runs beside the incrementer.
  logic [PC_W-1:0] pc_plus4, hit_tgt;
  assign pc_plus4      = fetch_pc + PC_W'(4);
  assign fetch_hit     = |way_hit;
  assign fetch_way     = way_hit[1];
  assign hit_tgt       = way_hit[1] ? f_tgt[1] : f_tgt[0];
  assign fetch_next_pc = (fetch_hit && fetch_taken) ? hit_tgt : pc_plus4;

  logic [WAYS*SETS-1:0] valid_flat;
  assign valid_flat = {vvec[1], vvec[0]};

  // R1
  reset_miss_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !fetch_hit);

  // R6
  single_hit_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(way_hit) && $onehot0(upd_match));

  // R5
  nonbranch_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!upd_valid || !upd_is_branch) |=> $stable(valid_flat));

endmodule

// File: tb/tb_btb_predictor.sv
module tb_btb_predictor;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] fetch_pc;
  logic        fetch_taken;
  logic [31:0] fetch_next_pc;
  logic        fetch_hit;
  logic        fetch_way;
  logic        upd_valid;
  logic [31:0] upd_pc;
  logic [31:0] upd_target;
  logic        upd_is_branch;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  btb_predictor dut (
    .clk(clk), .rst(rst),
    .fetch_pc(fetch_pc), .fetch_taken(fetch_taken),
    .fetch_next_pc(fetch_next_pc), .fetch_hit(fetch_hit), .fetch_way(fetch_way),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_target(upd_target),
    .upd_is_branch(upd_is_branch)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic look(input logic [31:0] pc, input bit tk, input bit eh,
                      input logic [31:0] en, input bit ew, input string req);
    @(negedge clk);
    fetch_pc = pc; fetch_taken = tk;
    #1;
    check(req, $sformatf("hit @%h", pc), 32'(fetch_hit), 32'(eh));
    check(req, $sformatf("next @%h", pc), fetch_next_pc, en);
    if (eh) check(req, $sformatf("way @%h", pc), 32'(fetch_way), 32'(ew));
  endtask

  task automatic upd(input logic [31:0] pc, input logic [31:0] tgt,
                     input bit vld, input bit isb);
    @(negedge clk);
    upd_valid = vld; upd_pc = pc; upd_target = tgt; upd_is_branch = isb;
    @(posedge clk);
    #1;
    upd_valid = 1'b0;
  endtask

  // R1: empty after reset, includes wrap of PC+4
  task automatic t_reset();
    look(32'h0000_0000, 1'b1, 1'b0, 32'h0000_0004, 1'b0, "R1");
    look(32'h8000_1234, 1'b1, 1'b0, 32'h8000_1238, 1'b0, "R1");
    look(32'hFFFF_FFFC, 1'b1, 1'b0, 32'h0000_0000, 1'b0, "R1");
  endtask

  // R4 and R3: first miss, train, hit taken and not taken
  task automatic t_train();
    look(32'h0000_1008, 1'b1, 1'b0, 32'h0000_100C, 1'b0, "R4");
    upd(32'h0000_1008, 32'h0000_2000, 1'b1, 1'b1);
    look(32'h0000_1008, 1'b1, 1'b1, 32'h0000_2000, 1'b0, "R4");
    look(32'h0000_1008, 1'b0, 1'b1, 32'h0000_100C, 1'b0, "R3");
  endtask

  // R9: same-cycle lookup sees old table
  task automatic t_same_cycle();
    @(negedge clk);
    upd_valid = 1'b1; upd_pc = 32'h0000_1010; upd_target = 32'h0000_3000;
    upd_is_branch = 1'b1;
    fetch_pc = 32'h0000_1010; fetch_taken = 1'b1;
    #1;
    check("R9", "hit same cycle", 32'(fetch_hit), 32'd0);
    check("R9", "next same cycle", fetch_next_pc, 32'h0000_1014);
    @(posedge clk);
    #1;
    upd_valid = 1'b0;
    check("R9", "hit after edge", 32'(fetch_hit), 32'd1);
    check("R9", "next after edge", fetch_next_pc, 32'h0000_3000);
  endtask

  // R5: non-branch and unqualified updates are ignored
  task automatic t_nonbranch();
    upd(32'h0000_1020, 32'h0000_4000, 1'b1, 1'b0);
    look(32'h0000_1020, 1'b1, 1'b0, 32'h0000_1024, 1'b0, "R5");
    upd(32'h0000_1020, 32'h0000_4000, 1'b0, 1'b1);
    look(32'h0000_1020, 1'b1, 1'b0, 32'h0000_1024, 1'b0, "R5");
  endtask

  // R2: full-address tag
  task automatic t_alias();
    look(32'h0000_1048, 1'b1, 1'b0, 32'h0000_104C, 1'b0, "R2");
    look(32'h8000_1008, 1'b1, 1'b0, 32'h8000_100C, 1'b0, "R2");
    look(32'h0000_1008, 1'b1, 1'b1, 32'h0000_2000, 1'b0, "R2");
  endtask

  // R6: in-place overwrite, way 1 stays free
  task automatic t_inplace();
    upd(32'h0000_1008, 32'h0000_2400, 1'b1, 1'b1);
    look(32'h0000_1008, 1'b1, 1'b1, 32'h0000_2400, 1'b0, "R6");
    upd(32'h0000_1048, 32'h0000_5000, 1'b1, 1'b1);
    look(32'h0000_1048, 1'b1, 1'b1, 32'h0000_5000, 1'b1, "R6");
    look(32'h0000_1008, 1'b1, 1'b1, 32'h0000_2400, 1'b0, "R6");
  endtask

  // R7 and R8: two ways per set, LRU replacement
  task automatic t_lru();
    upd(32'h0000_0130, 32'h0000_A000, 1'b1, 1'b1);
    upd(32'h0000_0170, 32'h0000_B000, 1'b1, 1'b1);
    look(32'h0000_0130, 1'b1, 1'b1, 32'h0000_A000, 1'b0, "R7");
    look(32'h0000_0170, 1'b1, 1'b1, 32'h0000_B000, 1'b1, "R7");
    look(32'h0000_0130, 1'b1, 1'b1, 32'h0000_A000, 1'b0, "R8");
    upd(32'h0000_01B0, 32'h0000_C000, 1'b1, 1'b1);
    look(32'h0000_0130, 1'b1, 1'b0, 32'h0000_0134, 1'b0, "R8");
    look(32'h0000_01B0, 1'b1, 1'b1, 32'h0000_C000, 1'b0, "R8");
    look(32'h0000_0170, 1'b1, 1'b1, 32'h0000_B000, 1'b1, "R8");
    upd(32'h0000_0170, 32'h0000_B400, 1'b1, 1'b1);
    upd(32'h0000_01F0, 32'h0000_D000, 1'b1, 1'b1);
    look(32'h0000_01B0, 1'b1, 1'b0, 32'h0000_01B4, 1'b0, "R8");
    look(32'h0000_01F0, 1'b1, 1'b1, 32'h0000_D000, 1'b0, "R8");
    look(32'h0000_0170, 1'b1, 1'b1, 32'h0000_B400, 1'b1, "R8");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; fetch_pc = '0; fetch_taken = 1'b0;
    upd_valid = 1'b0; upd_pc = '0; upd_target = '0; upd_is_branch = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    t_reset();
    t_train();
    t_same_cycle();
    t_nonbranch();
    t_alias();
    t_inplace();
    t_lru();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule